// File: doc/BRIEF.md
# Bipolar Return-to-Zero Serial Word Transmitter

This block turns a parallel data word into a self-clocked serial stream on two digital lines, one high leg and one low leg. A single start strobe loads the word, computes its parity bit and shifts it out least-significant position first. Each bit occupies one cell. In the first half of the cell, the high leg pulses for a one or the low leg pulses for a zero. In the second half, both legs return to null.

Runtime inputs, sampled when a word is accepted, choose the cell length (10 or 80 reference clocks), the word length (32 or 25 positions) and the parity sense (odd normally, even for exercising parity checkers). After the last position, four null cells separate words. A busy flag covers both the word and the gap. A loopback output carries the serial data level so that a receiver can be fed without line drivers.

Top module: `serial_word_tx`

## Requirements
- R1: While reset is held and after its release, busy, line_hi, line_lo and loop_data are 0 until a start is accepted.
- R2: Input tx_word[i] is transmitted at position i+1, positions going out in ascending order from 1. Positions 1-8 carry the label, 9-10 source/destination, 11-28 data, 29-31 sign/status, and 32 (or 25) parity.
- R3: In each cell, line_hi is 1 during the first half when the bit is 1, and line_lo is 1 during the first half when it is 0. Both are 0 during the second half, and they are never 1 together.
- R4: With slow_rate=0 a cell lasts 10 clocks. With slow_rate=1 a cell lasts 80 clocks.
- R5: With short_word=0 a word has 32 positions, and parity at position 32 covers tx_word[30:0]. With short_word=1 a word has 25 positions, parity at position 25 covers tx_word[23:0], and tx_word[30:24] has no effect.
- R6: With parity_even=0 the count of ones over all positions, parity included, is odd. With parity_even=1 it is even.
- R7: Busy rises on the clock after an accepted start and stays 1 for (positions + 4) cells, with both lines at 0 during the last 4 cells.
- R8: A start seen while busy is 1 is ignored: no word follows and busy falls at the time set by the word in progress.
- R9: tx_word, slow_rate, short_word and parity_even are sampled only at the accepting edge. Changes during a word alter nothing in it.
- R10: While a word is being sent, loop_data equals the current position's bit for the whole cell, and the line outputs keep running. loop_data is 0 in the gap and when idle.
- R11: The first cell of a word begins in the clock cycle right after the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to send tx_word, honoured only when idle |
| tx_word | input | 31 | Word without parity; bit i goes to position i+1 |
| slow_rate | input | 1 | 0: 10 clocks per cell, 1: 80 clocks per cell |
| short_word | input | 1 | 0: 32 positions, 1: 25 positions |
| parity_even | input | 1 | 0: odd parity, 1: even parity |
| line_hi | output | 1 | High leg of the bipolar return-to-zero line |
| line_lo | output | 1 | Low leg of the bipolar return-to-zero line |
| loop_data | output | 1 | Serial data level for receiver loopback |
| busy | output | 1 | Word or inter-word gap in progress |

## Verification
Every output is a combinational function of registers loaded at the accepting edge. Clock cycle c (counted from 0 after that edge) therefore shows position c/D in phase c mod D, where D is the cell length, and busy stays 1 up to c = (N+4)·D−1. The bench samples on the falling edge of every one of those cycles and compares each one against a model computed from the requirements. It also checks a few cycles past the end of busy. This catches an off-by-one in either the cell counter or the gap length at the exact cycle where it appears. Mid-word disturbances (a second start, changed controls, a changed word) are applied on falling edges, and the same per-cycle comparison shows that they had no effect.

// File: rtl/swtx_pkg.sv
// Shared constants and state type for the serial word transmitter.
package swtx_pkg;
    localparam int LONG_BITS  = 32;
    localparam int SHORT_BITS = 25;
    localparam int GAP_CELLS  = 4;
    localparam int DIV_FAST   = 10;
    localparam int DIV_SLOW   = 80;
    localparam int CNT_W      = $clog2(DIV_SLOW);
    localparam int POS_W      = $clog2(LONG_BITS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/swtx_cell_timer.sv
// Counts reference clocks inside one bit cell.
// Assumes: the rate select is held stable while run is high.
module swtx_cell_timer
    import swtx_pkg::*;
#(
    parameter int DIV_F = DIV_FAST,
    parameter int DIV_S = DIV_SLOW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic first_half,
    output logic cell_end
);
    localparam int CW = $clog2(DIV_S);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic [CW-1:0] half;

    // Select the cell length and its midpoint.
    always_comb begin
        last = slow ? CW'(DIV_S - 1) : CW'(DIV_F - 1);
        half = slow ? CW'(DIV_S / 2) : CW'(DIV_F / 2);
    end

    assign cell_end   = run && (cnt == last);
    assign first_half = cnt < half;

    // Advance the clock count within a cell; wrap at the end of the cell.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cell_end) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/swtx_framer.sv
// Builds the framed word (data plus parity) and shifts it out, lowest position first.
// Assumes: load and shift are never high in the same cycle.
module swtx_framer
    import swtx_pkg::*;
#(
    parameter int LW = LONG_BITS,
    parameter int SW = SHORT_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [LW-2:0] word_in,
    input  logic          short_in,
    input  logic          even_in,
    output logic          cur_bit
);
    logic [LW-2:0] masked;
    logic          par;
    logic [LW-1:0] frame;
    logic [LW-1:0] sreg;

    // Mask off positions beyond the chosen length and form the parity bit.
    always_comb begin
        for (int i = 0; i < LW - 1; i++)
            masked[i] = word_in[i] & (!short_in || (i < SW - 1));
        par = (^masked) ^ !even_in;
    end

    // Place parity directly after the last data position for the chosen length.
    always_comb begin
        for (int i = 0; i < LW; i++) begin
            if (short_in)
                frame[i] = (i < SW - 1) ? masked[i] : ((i == SW - 1) ? par : 1'b0);
            else
                frame[i] = (i < LW - 1) ? masked[i] : par;
        end
    end

    // Hold the framed word; move to the next position on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= frame;
        else if (shift) sreg <= {1'b0, sreg[LW-1:1]};
    end

    assign cur_bit = sreg[0];
endmodule

// File: rtl/swtx_sequencer.sv
// Walks idle, word and gap phases; latches the per-word controls at acceptance.
// Assumes: cell_end pulses once per cell while running.
module swtx_sequencer
    import swtx_pkg::*;
#(
    parameter int LW  = LONG_BITS,
    parameter int SW  = SHORT_BITS,
    parameter int GAP = GAP_CELLS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic slow_in,
    input  logic short_in,
    input  logic cell_end,
    output logic load,
    output logic shift,
    output logic running,
    output logic sending,
    output logic slow_q,
    output logic short_q
);
    localparam int PW = $clog2(LW);

    tx_state_e     state;
    logic [PW-1:0] idx;
    logic [PW-1:0] last_pos;

    assign last_pos = short_q ? PW'(SW - 1) : PW'(LW - 1);
    assign load     = start && (state == ST_IDLE);
    assign shift    = (state == ST_SEND) && cell_end && (idx != last_pos);
    assign running  = state != ST_IDLE;
    assign sending  = state == ST_SEND;

    // Phase and position/gap counter updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            slow_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_SEND;
                    idx     <= '0;
                    slow_q  <= slow_in;
                    short_q <= short_in;
                end
                ST_SEND: if (cell_end) begin
                    if (idx == last_pos) begin
                        state <= ST_GAP;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_GAP: if (cell_end) begin
                    if (idx == PW'(GAP - 1)) state <= ST_IDLE;
                    else                     idx   <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_word_tx.sv
// Top level: bipolar return-to-zero word transmitter with loopback output.
// Assumes: start is synchronous to clk.
module serial_word_tx
    import swtx_pkg::*;
#(
    parameter int LW     = LONG_BITS,
    parameter int SW     = SHORT_BITS,
    parameter int GAP    = GAP_CELLS,
    parameter int DIV_F  = DIV_FAST,
    parameter int DIV_S  = DIV_SLOW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-2:0] tx_word,
    input  logic          slow_rate,
    input  logic          short_word,
    input  logic          parity_even,
    output logic          line_hi,
    output logic          line_lo,
    output logic          loop_data,
    output logic          busy
);
    logic load, shift, running, sending, slow_q, short_q;
    logic first_half, cell_end, cur_bit;

    swtx_sequencer #(.LW(LW), .SW(SW), .GAP(GAP)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .slow_in(slow_rate), .short_in(short_word), .cell_end(cell_end),
        .load(load), .shift(shift), .running(running), .sending(sending),
        .slow_q(slow_q), .short_q(short_q)
    );

    swtx_cell_timer #(.DIV_F(DIV_F), .DIV_S(DIV_S)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(running), .slow(slow_q),
        .first_half(first_half), .cell_end(cell_end)
    );

    swtx_framer #(.LW(LW), .SW(SW)) u_framer (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .word_in(tx_word), .short_in(short_word), .even_in(parity_even),
        .cur_bit(cur_bit)
    );

    // Drive the two legs in the first half cell, null in the second.
    assign line_hi   = sending && first_half && cur_bit;
    assign line_lo   = sending && first_half && !cur_bit;
    assign loop_data = sending && cur_bit;
    assign busy      = running;
endmodule

// File: rtl/swtx_checker.sv
// Protocol checks for serial_word_tx, attached through bind.
module swtx_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic line_hi,
    input logic line_lo,
    input logic loop_data,
    input logic slow_q,
    input logic short_q
);
    // R3: legs never both active
    a_r3_legs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));
    // R10: loopback agrees with the leg being driven
    a_r10_loop_hi: assert property (@(posedge clk) disable iff (!rst_n)
        line_hi |-> loop_data);
    a_r10_loop_lo: assert property (@(posedge clk) disable iff (!rst_n)
        line_lo |-> !loop_data);
    // R7: nothing on the line outside busy
    a_r7_idle_null: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_hi && !line_lo && !loop_data));
    // R8: busy only rises after a start
    a_r8_rise_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R9: latched controls steady through a word
    a_r9_controls_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(slow_q) && $stable(short_q)));
endmodule

bind serial_word_tx swtx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .line_hi(line_hi), .line_lo(line_lo), .loop_data(loop_data),
    .slow_q(slow_q), .short_q(short_q)
);

// File: tb/serial_word_tx_tb.sv
`timescale 1ns/1ps
module serial_word_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [30:0] tx_word = '0;
    logic        slow_rate = 1'b0;
    logic        short_word = 1'b0;
    logic        parity_even = 1'b0;
    logic        line_hi, line_lo, loop_data, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    serial_word_tx u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .slow_rate(slow_rate), .short_word(short_word), .parity_even(parity_even),
        .line_hi(line_hi), .line_lo(line_lo), .loop_data(loop_data), .busy(busy)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected bit at 0-based position p: R2 ordering, R5 length, R6 parity.
    function automatic logic exp_bit(input logic [30:0] w, input logic sh,
                                     input logic ev, input int p);
        int n = sh ? 25 : 32;
        logic x = 1'b0;
        for (int i = 0; i < n - 1; i++) x ^= w[i];
        if (p < n - 1) return w[p];
        if (p == n - 1) return ev ? x : ~x;
        return 1'b0;
    endfunction

    // R1: outputs quiet during and after reset.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 1'b0);
        check("R1 line_hi in reset", line_hi, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy after reset", busy, 1'b0);
        check("R1 line_lo after reset", line_lo, 1'b0);
        check("R1 loop_data after reset", loop_data, 1'b0);
    endtask

    // Send one word and compare every cycle (R2 R3 R4 R5 R6 R7 R10 R11).
    // With disturb set, a mid-word start and changed inputs test R8 and R9.
    task automatic t_word(input logic [30:0] w, input logic sl, input logic sh,
                          input logic ev, input bit disturb);
        int d = sl ? 80 : 10;
        int n = sh ? 25 : 32;
        int total = (n + 4) * d;
        @(negedge clk);
        tx_word = w; slow_rate = sl; short_word = sh; parity_even = ev; start = 1'b1;
        for (int c = 0; c < total + 4; c++) begin
            int pos = c / d;
            bit fh = (c % d) < d / 2;
            logic b;
            string tag;
            @(negedge clk);
            if (c == 0) start = 1'b0;
            b = exp_bit(w, sh, ev, pos);
            tag = (c >= n * d) ? "R7 gap/idle" : ((pos == n - 1) ? "R6 parity cell" : "R3 data cell");
            if (c < n * d) begin
                check(tag, line_hi, fh && b);
                check(tag, line_lo, fh && !b);
                check("R10 loop_data", loop_data, b);
            end else begin
                check(tag, line_hi, 1'b0);
                check(tag, line_lo, 1'b0);
                check("R10 loop_data idle", loop_data, 1'b0);
            end
            check(c < total ? "R7 busy held" : "R8 busy dropped", busy, c < total);
            if (disturb && c == 2 * d + 3) begin
                start = 1'b1; tx_word = ~w; slow_rate = ~sl; short_word = ~sh; parity_even = ~ev;
            end
            if (disturb && c == 2 * d + 4) start = 1'b0;
            if (disturb && c == total - 2) start = 1'b0;
        end
    endtask

    initial begin
        t_reset();
        t_word(31'h2A5C_3E91, 1'b0, 1'b0, 1'b0, 1'b0);  // R4 fast, R5 long, R6 odd
        t_word(31'h2A5C_3E91, 1'b0, 1'b0, 1'b1, 1'b0);  // R6 even
        t_word(31'h7F00_0001, 1'b0, 1'b1, 1'b0, 1'b0);  // R5 short: high bits ignored
        t_word(31'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b0);  // R6 even on all zeros
        t_word(31'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0);  // R4 slow, R11 timing
        t_word(31'h5555_AAAA, 1'b1, 1'b1, 1'b1, 1'b0);  // R4 slow short
        t_word(31'h0F0F_F0F0, 1'b0, 1'b0, 1'b0, 1'b1);  // R8 R9 disturbance
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule